// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block drives a 32-pin general-purpose I/O port from a small register bus. Software never rewrites the whole output latch. It writes a bit mask to a set address or a clear address, and only the selected pins change. Any such write also makes those pins outputs. A separate release address hands selected pins back to input mode. The pad buffer is modelled as three vectors: drive value, drive enable and sampled input.

The input path starts dead. A small two-state machine holds it in `LOCKED` until the first write of any value to the input-enable address. That write is the transition `LOCKED -> LIVE`, and no transition leads back except reset. While the machine is `LIVE`, pad levels pass through a two-flop synchronizer into the pin-state register, which software reads back. While it is `LOCKED`, the synchronizer is fed zeros.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, `pad_oe` is all zero, `pad_out` is all zero, and the pin-state read returns zero.
- R2: A write to address 0 (set) makes `pad_out` bit n high from the next cycle for every bit n set in the data. All other bits are unchanged.
- R3: A write to address 1 (clear) makes `pad_out` bit n low from the next cycle for every bit n set in the data. All other bits are unchanged.
- R4: A write to address 0 or 1 also sets `pad_oe` bit n for every selected bit n. Unselected bits of `pad_oe` are unchanged.
- R5: A write to address 2 (release) clears `pad_oe` bit n for every selected bit n. `pad_out` is unchanged.
- R6: Once the input path is live, a read of address 4 (pin state) returns the value `pad_in` had two clock edges earlier, bit n for pin n.
- R7: Until address 3 (input enable) receives a write, the pin-state read returns zero whatever `pad_in` holds. One write with any data, zero included, enables the path permanently until reset.
- R8: Reads of addresses 0, 1, 2, 3 and 5 to 7 return zero. Writes to addresses 4 to 7 change neither `pad_out` nor `pad_oe`.
- R9: `bus_rdata` follows `bus_addr` combinationally. Every access completes in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write mask / data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Levels seen at the pads |
| pad_out | output | 32 | Drive value to the pads |
| pad_oe | output | 32 | Drive enable to the pads, 1 = output |

## Verification
A wrong output latch or direction bit shows at `pad_out` or `pad_oe` one cycle after the offending write. Nothing hides those vectors. A stuck or early `LIVE` state shows on the first pin-state read after the input pins are driven nonzero. With the input path live, a synchronizer with the wrong depth returns a pad change one cycle early or late, so the bench reads that register on both sides of the expected edge.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SET       = 3'd0;
    localparam logic [ADDR_W-1:0] A_CLR       = 3'd1;
    localparam logic [ADDR_W-1:0] A_RELEASE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_IN_EN     = 3'd3;
    localparam logic [ADDR_W-1:0] A_PIN_STATE = 3'd4;

    typedef enum logic {
        IN_LOCKED = 1'b0,
        IN_LIVE   = 1'b1
    } in_state_e;
endpackage

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
    parameter int PIN_COUNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic                 rel_we,
    input  logic [PIN_COUNT-1:0] mask,
    output logic [PIN_COUNT-1:0] drive,
    output logic [PIN_COUNT-1:0] drive_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= '0;
        end else if (set_we) begin
            drive <= drive | mask;
        end else if (clr_we) begin
            drive <= drive & ~mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_en <= '0;
        end else if (set_we || clr_we) begin
            drive_en <= drive_en | mask;
        end else if (rel_we) begin
            drive_en <= drive_en & ~mask;
        end
    end
endmodule

// File: rtl/gpio_in_gate.sv
module gpio_in_gate
    import gpio_setclr_pkg::*;
#(
    parameter int PIN_COUNT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_we,
    input  logic [PIN_COUNT-1:0] pad_level,
    output logic [PIN_COUNT-1:0] level_sync,
    output logic                 live
);
    in_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IN_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_LOCKED: if (en_we) state_d = IN_LIVE;
            IN_LIVE:   state_d = IN_LIVE;
        endcase
    end

    always_comb begin
        live = (state_q == IN_LIVE);
    end

    logic [PIN_COUNT-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= live ? pad_level : '0;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign level_sync = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_setclr_pkg::*;
#(
    parameter int PIN_COUNT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [PIN_COUNT-1:0] bus_wdata,
    output logic [PIN_COUNT-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe
);
    logic                 set_we, clr_we, rel_we, en_we;
    logic                 in_live;
    logic [PIN_COUNT-1:0] pin_state;

    always_comb begin
        set_we = bus_wr && (bus_addr == A_SET);
        clr_we = bus_wr && (bus_addr == A_CLR);
        rel_we = bus_wr && (bus_addr == A_RELEASE);
        en_we  = bus_wr && (bus_addr == A_IN_EN);
    end

    gpio_out_latch #(.PIN_COUNT(PIN_COUNT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .rel_we   (rel_we),
        .mask     (bus_wdata),
        .drive    (pad_out),
        .drive_en (pad_oe)
    );

    gpio_in_gate #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (en_we),
        .pad_level  (pad_in),
        .level_sync (pin_state),
        .live       (in_live)
    );

    always_comb begin
        bus_rdata = (bus_addr == A_PIN_STATE) ? pin_state : '0;
    end
endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk
    import gpio_setclr_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [PIN_COUNT-1:0] bus_wdata,
    input logic [PIN_COUNT-1:0] bus_rdata,
    input logic [PIN_COUNT-1:0] pad_out,
    input logic [PIN_COUNT-1:0] pad_oe,
    input logic                 in_live,
    input logic [PIN_COUNT-1:0] pin_state
);
    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (pad_out == '0 && pad_oe == '0)); // R1
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR) |=> ((pad_out & $past(bus_wdata)) == '0)); // R3
    AST_WRITE_MAKES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata))); // R4
    AST_RELEASE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RELEASE) |=> ((pad_oe & $past(bus_wdata)) == '0)); // R5
    AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_live |-> (pin_state == '0)); // R7
    AST_LIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        in_live |=> in_live); // R7
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_PIN_STATE) |-> (bus_rdata == '0)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(pad_out)); // R8
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .in_live   (in_live),
    .pin_state (pin_state)
);

// File: tb/gpio_setclr_port_bench.sv
module gpio_setclr_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_out = '0;
    logic [31:0] exp_oe = '0;

    always #5 clk = ~clk;

    gpio_setclr_port u_gpio_setclr_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_out"}, pad_out, exp_out);
        check({req, " pad_oe"}, pad_oe, exp_oe);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd4, d);
        check("R1 pin state", d, 32'h0);
        check_pads("R1");
    endtask

    task automatic t_locked;
        logic [31:0] d;
        pad_in = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        rd(3'd4, d);
        check("R7 locked read", d, 32'h0);
        wr(3'd4, 32'h1234_5678);
        check_pads("R8 pin-state write");
        wr(3'd7, 32'hFFFF_FFFF);
        check_pads("R8 unmapped write");
    endtask

    task automatic t_enable;
        logic [31:0] d;
        pad_in = 32'hC3A5_0F01;
        wr(3'd3, 32'h0);
        @(negedge clk);
        rd(3'd4, d);
        check("R6 one edge after enable", d, 32'h0);
        @(negedge clk);
        rd(3'd4, d);
        check("R7 enabled by zero write", d, 32'hC3A5_0F01);
        pad_in = 32'h8000_0001;
        @(negedge clk);
        rd(3'd4, d);
        check("R6 one edge after change", d, 32'hC3A5_0F01);
        @(negedge clk);
        rd(3'd4, d);
        check("R6 two edges after change", d, 32'h8000_0001);
        check("R9 same-cycle read", bus_rdata, 32'h8000_0001);
        wr(3'd3, 32'hFFFF_FFFF);
        pad_in = 32'h0000_FFFF;
        repeat (2) @(negedge clk);
        rd(3'd4, d);
        check("R7 stays live", d, 32'h0000_FFFF);
    endtask

    task automatic t_set_clr;
        wr(3'd0, 32'hA5A5_0000);
        exp_out = 32'hA5A5_0000; exp_oe = 32'hA5A5_0000;
        check_pads("R2 R4 set");
        wr(3'd0, 32'h8000_0001);
        exp_out |= 32'h8000_0001; exp_oe |= 32'h8000_0001;
        check_pads("R2 edge pins");
        wr(3'd1, 32'h00F0_0F0F);
        exp_out &= ~32'h00F0_0F0F; exp_oe |= 32'h00F0_0F0F;
        check_pads("R3 R4 clear");
        wr(3'd1, 32'hA000_0000);
        exp_out &= ~32'hA000_0000;
        check_pads("R3 partial clear");
    endtask

    task automatic t_release;
        wr(3'd2, 32'hFFFF_0000);
        exp_oe &= ~32'hFFFF_0000;
        check_pads("R5 release");
        wr(3'd1, 32'h0001_0000);
        exp_out &= ~32'h0001_0000; exp_oe |= 32'h0001_0000;
        check_pads("R4 clear re-drives");
    endtask

    task automatic t_read_zero;
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            if (a != 4) begin
                rd(3'(a), d);
                check($sformatf("R8 read addr %0d", a), d, 32'h0);
            end
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_locked();
        t_enable();
        t_set_clr();
        t_release();
        t_read_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule